// File: doc/BRIEF.md
# Bank-Selected Clock Output Controller

This block is the digital control and output stage of a programmable clock synthesizer. It runs on the VCO-rate clock and divides it by twice a 5-bit post-divider value. The result drives a complementary output pair, and that pair has its own enable for tristate control. The block holds two configuration banks, each fixed by parameters. A bank carries a post-divider value, a 6-bit feedback multiplier, a drive-strength bit and a 2-bit charge-pump level. The feedback, pump and drive fields of the active bank are presented on registered ports for the external PLL and pad models.

A single shared pin takes one of four roles, chosen by `mode_i`:
- it drives the reference clock out;
- it drives the reference clock divided by two out;
- it acts as an output-enable input;
- it acts as a live bank-select input.

A bank switch requested through the pin is deferred to the divider's next terminal count. The new divider value and the new exported fields therefore take effect together, and no shortened pulse appears on the outputs.

Top module: `clkout_bank_ctrl`

## Requirements
- R1: The effective divider value Pe is the active bank's post-divider value. `clk_p_o` holds each level for exactly Pe VCO cycles, which gives a period of 2·Pe cycles and a 50% duty cycle. The counter starts at 0 after reset, and the first edge of `clk_p_o` comes Pe cycles after reset is released.
- R2: `clk_n_o` is always the inverse of `clk_p_o`, both during reset and after it.
- R3: `mode_i` encoding for the shared pin:
  - mode_i=0: `pin_o` is the reference sampled on the previous VCO edge, and `pin_oe_o`=1.
  - mode_i=1: `pin_o` is a reference-divided-by-two signal, and `pin_oe_o`=1. This signal toggles on every VCO edge that sees `ref_i` high after a low sample.
  - mode_i=2 or mode_i=3: `pin_o`=0 and `pin_oe_o`=0.
- R4: In mode 2, a low `pin_i` drives `main_oe_o` to 0 from the next VCO edge, and a high `pin_i` drives it to 1. In every other mode `main_oe_o` becomes 1 on the next edge.
- R5: In mode 3, `pin_i`=0 requests bank 0 and `pin_i`=1 requests bank 1. Every other mode requests bank 1.
- R6: The requested bank is taken only at the edge where the divider counter reaches Pe−1. A request that is withdrawn before that edge has no effect on any output.
- R7: A post-divider value of 0 is treated as 1, which divides by 2.
- R8: `fb_m_o`, `pump_o` and `drive_o` are registered copies of the active bank's fields. They change only at the same edge as the bank switch, together with the new Pe.
- R9: While `rst_ni` is low, the block is held in a fixed state:
  - `clk_p_o`=0 and `clk_n_o`=1;
  - `main_oe_o`=1;
  - the counter is cleared;
  - bank 1 is active, so its fields appear on `fb_m_o`, `pump_o` and `drive_o`;
  - the reference half-rate state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco_i | input | 1 | VCO-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference clock level, sampled on clk_vco_i |
| mode_i | input | 2 | Role of the shared pin (0 ref, 1 ref/2, 2 enable, 3 bank select) |
| pin_i | input | 1 | Level seen on the shared pin (pulled high when undriven) |
| pin_o | output | 1 | Value driven onto the shared pin in modes 0 and 1 |
| pin_oe_o | output | 1 | Drive enable for the shared pin |
| clk_p_o | output | 1 | Divided clock, true phase |
| clk_n_o | output | 1 | Divided clock, inverted phase |
| main_oe_o | output | 1 | Enable of the main output pair; 0 means tristate |
| fb_m_o | output | 6 | Feedback multiplier of the active bank |
| pump_o | output | 2 | Charge-pump level of the active bank |
| drive_o | output | 1 | Drive strength of the active bank (1 = high) |

## Verification
The hardest case to reach is a bank-select pulse that arrives between terminal counts and is withdrawn before the next one. Such a pulse must leave the divider, the outputs and the exported fields untouched. Only the pulse's phase against the hidden counter decides the outcome. The stimulus therefore sends one-cycle low pulses on the pin at a spacing that does not share a factor with the divide period, so the pulses sweep every counter phase, both terminal and non-terminal. A long pseudo-random section follows, with random modes and pin levels, and then a reset taken while bank 0 is active.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    typedef enum logic [1:0] {
        PIN_REF      = 2'd0,
        PIN_REF_HALF = 2'd1,
        PIN_OE       = 2'd2,
        PIN_BSEL     = 2'd3
    } pin_mode_e;

endpackage

// File: rtl/clkgen_refpin.sv
module clkgen_refpin
    import clkgen_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      ref_i,
    input  pin_mode_e mode_i,
    output logic      pin_o,
    output logic      pin_oe_o
);

    typedef struct packed {
        logic smp;
        logic half;
    } ref_st_t;

    ref_st_t st_d, st_q;
    logic    ref_rise;

    always_comb begin
        st_d     = st_q;
        ref_rise = ref_i && !st_q.smp;
        st_d.smp = ref_i;
        if (ref_rise) begin
            st_d.half = ~st_q.half;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (mode_i)
            PIN_REF:      pin_o = st_q.smp;
            PIN_REF_HALF: pin_o = st_q.half;
            default:      pin_o = 1'b0;
        endcase
        pin_oe_o = (mode_i == PIN_REF) || (mode_i == PIN_REF_HALF);
    end

    AST_HALF_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_i && !st_q.smp) |=> (st_q.half != $past(st_q.half))); // R3
    AST_HALF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ref_i && !st_q.smp) |=> $stable(st_q.half)); // R3

endmodule

// File: rtl/clkgen_divider.sv
module clkgen_divider #(
    parameter int unsigned PW = 5,
    parameter int unsigned MW = 6,
    parameter int unsigned CW = 2,
    parameter logic [PW-1:0] B0_P = '0,
    parameter logic [MW-1:0] B0_M = '0,
    parameter logic [CW-1:0] B0_CP = '0,
    parameter logic          B0_DRV = 1'b0,
    parameter logic [PW-1:0] B1_P = '0,
    parameter logic [MW-1:0] B1_M = '0,
    parameter logic [CW-1:0] B1_CP = '0,
    parameter logic          B1_DRV = 1'b0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_bank_i,
    output logic          tog_o,
    output logic [MW-1:0] m_o,
    output logic [CW-1:0] cp_o,
    output logic          drv_o
);

    localparam logic [PW-1:0] ONE_P   = PW'(1);
    localparam logic [PW-1:0] B0_PEFF = (B0_P == '0) ? ONE_P : B0_P;
    localparam logic [PW-1:0] B1_PEFF = (B1_P == '0) ? ONE_P : B1_P;

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          tog;
        logic          bank;
        logic [PW-1:0] peff;
        logic [MW-1:0] m;
        logic [CW-1:0] cp;
        logic          drv;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    term;

    always_comb begin
        st_d = st_q;
        term = (st_q.cnt == (st_q.peff - ONE_P));
        if (term) begin
            st_d.cnt  = '0;
            st_d.tog  = ~st_q.tog;
            st_d.bank = req_bank_i;
            if (req_bank_i) begin
                st_d.peff = B1_PEFF;
                st_d.m    = B1_M;
                st_d.cp   = B1_CP;
                st_d.drv  = B1_DRV;
            end else begin
                st_d.peff = B0_PEFF;
                st_d.m    = B0_M;
                st_d.cp   = B0_CP;
                st_d.drv  = B0_DRV;
            end
        end else begin
            st_d.cnt = st_q.cnt + ONE_P;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, tog: 1'b0, bank: 1'b1, peff: B1_PEFF,
                      m: B1_M, cp: B1_CP, drv: B1_DRV};
        end else begin
            st_q <= st_d;
        end
    end

    assign tog_o = st_q.tog;
    assign m_o   = st_q.m;
    assign cp_o  = st_q.cp;
    assign drv_o = st_q.drv;

    AST_CNT_BELOW_P: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < st_q.peff); // R1
    AST_PEFF_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.peff != '0); // R7
    AST_TOG_AT_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        term |=> (st_q.tog != $past(st_q.tog))); // R1
    AST_TOG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !term |=> $stable(st_q.tog)); // R1
    AST_BANK_AT_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !term |=> ($stable(st_q.bank) && $stable(st_q.peff))); // R6
    AST_FIELDS_AT_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !term |=> ($stable(st_q.m) && $stable(st_q.cp) && $stable(st_q.drv))); // R8

endmodule

// File: rtl/clkout_bank_ctrl.sv
module clkout_bank_ctrl
    import clkgen_pkg::*;
#(
    parameter int unsigned PW = 5,
    parameter int unsigned MW = 6,
    parameter int unsigned CW = 2,
    parameter logic [PW-1:0] B0_P = 5'd0,
    parameter logic [MW-1:0] B0_M = 6'd20,
    parameter logic [CW-1:0] B0_CP = 2'd1,
    parameter logic          B0_DRV = 1'b0,
    parameter logic [PW-1:0] B1_P = 5'd3,
    parameter logic [MW-1:0] B1_M = 6'd45,
    parameter logic [CW-1:0] B1_CP = 2'd3,
    parameter logic          B1_DRV = 1'b1
) (
    input  logic          clk_vco_i,
    input  logic          rst_ni,
    input  logic          ref_i,
    input  logic [1:0]    mode_i,
    input  logic          pin_i,
    output logic          pin_o,
    output logic          pin_oe_o,
    output logic          clk_p_o,
    output logic          clk_n_o,
    output logic          main_oe_o,
    output logic [MW-1:0] fb_m_o,
    output logic [CW-1:0] pump_o,
    output logic          drive_o
);

    typedef struct packed {
        logic oe;
    } ctl_st_t;

    pin_mode_e mode;
    ctl_st_t   ctl_d, ctl_q;
    logic      req_bank;
    logic      tog;

    assign mode = pin_mode_e'(mode_i);

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.oe = !((mode == PIN_OE) && !pin_i);
        req_bank = (mode == PIN_BSEL) ? pin_i : 1'b1;
    end

    always_ff @(posedge clk_vco_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q.oe <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    clkgen_divider #(
        .PW(PW), .MW(MW), .CW(CW),
        .B0_P(B0_P), .B0_M(B0_M), .B0_CP(B0_CP), .B0_DRV(B0_DRV),
        .B1_P(B1_P), .B1_M(B1_M), .B1_CP(B1_CP), .B1_DRV(B1_DRV)
    ) u_div (
        .clk_i      (clk_vco_i),
        .rst_ni     (rst_ni),
        .req_bank_i (req_bank),
        .tog_o      (tog),
        .m_o        (fb_m_o),
        .cp_o       (pump_o),
        .drv_o      (drive_o)
    );

    clkgen_refpin u_refpin (
        .clk_i    (clk_vco_i),
        .rst_ni   (rst_ni),
        .ref_i    (ref_i),
        .mode_i   (mode),
        .pin_o    (pin_o),
        .pin_oe_o (pin_oe_o)
    );

    assign clk_p_o   = tog;
    assign clk_n_o   = ~tog;
    assign main_oe_o = ctl_q.oe;

    AST_OE_FOLLOWS_PIN: assert property (@(posedge clk_vco_i) disable iff (!rst_ni)
        (mode == PIN_OE) |=> (main_oe_o == $past(pin_i))); // R4
    AST_OE_ON_OTHER: assert property (@(posedge clk_vco_i) disable iff (!rst_ni)
        (mode != PIN_OE) |=> main_oe_o); // R4

endmodule

// File: tb/clkout_bank_ctrl_tb.sv
module clkout_bank_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       pin_i = 1'b1;
    logic       pin_o, pin_oe_o, clk_p_o, clk_n_o, main_oe_o, drive_o;
    logic [5:0] fb_m_o;
    logic [1:0] pump_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    int e_cnt = 0, e_tog = 0, e_bank = 1, e_peff = 3, e_oe = 1, e_ref = 0, e_half = 0;

    always #4 clk = ~clk;

    clkout_bank_ctrl u_dut (
        .clk_vco_i (clk), .rst_ni (rst_n), .ref_i (ref_i), .mode_i (mode_i),
        .pin_i (pin_i), .pin_o (pin_o), .pin_oe_o (pin_oe_o),
        .clk_p_o (clk_p_o), .clk_n_o (clk_n_o), .main_oe_o (main_oe_o),
        .fb_m_o (fb_m_o), .pump_o (pump_o), .drive_o (drive_o)
    );

    function automatic int peff_of(int b);
        int p;
        p = b ? 3 : 0;
        return (p == 0) ? 1 : p; // R7: zero means one
    endfunction
    function automatic int m_of(int b);   return b ? 45 : 20; endfunction
    function automatic int cp_of(int b);  return b ? 3 : 1;   endfunction
    function automatic int drv_of(int b); return b ? 1 : 0;   endfunction

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            e_cnt = 0; e_tog = 0; e_bank = 1; e_peff = peff_of(1);
            e_oe = 1; e_ref = 0; e_half = 0;
        end else begin
            int req;
            req = (mode_i == 2'd3) ? int'(pin_i) : 1;
            if (e_cnt == e_peff - 1) begin
                e_cnt = 0;
                e_tog = 1 - e_tog;
                e_bank = req;
                e_peff = peff_of(req);
            end else begin
                e_cnt++;
            end
            e_oe = (mode_i == 2'd2 && pin_i == 1'b0) ? 0 : 1;
            if (ref_i && e_ref == 0) e_half = 1 - e_half;
            e_ref = int'(ref_i);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_pin;
            exp_pin = (mode_i == 2'd0) ? e_ref : (mode_i == 2'd1) ? e_half : 0;
            chk("R1 R7 clk_p", clk_p_o, e_tog);
            chk("R2 clk_n", clk_n_o, 1 - e_tog);
            chk("R4 main_oe", main_oe_o, e_oe);
            chk("R3 pin_oe", pin_oe_o, (mode_i < 2'd2) ? 1 : 0);
            chk("R3 pin_o", pin_o, exp_pin);
            chk("R5 R6 R8 fb_m", fb_m_o, m_of(e_bank));
            chk("R6 R8 pump", pump_o, cp_of(e_bank));
            chk("R8 drive", drive_o, drv_of(e_bank));
        end
    end

    // reference clock: toggles every 3 VCO cycles
    int rdiv = 0;
    always @(posedge clk) begin
        #1;
        rdiv++;
        if (rdiv == 3) begin
            rdiv = 0;
            ref_i = ~ref_i;
        end
    end

    task automatic step(int m, int p);
        @(posedge clk);
        #2;
        mode_i = 2'(m);
        pin_i = 1'(p);
    endtask

    task automatic reset_checks();
        chk("R9 clk_p", clk_p_o, 0);
        chk("R2 R9 clk_n", clk_n_o, 1);
        chk("R9 main_oe", main_oe_o, 1);
        chk("R9 fb_m", fb_m_o, 45);
        chk("R9 pump", pump_o, 3);
        chk("R9 drive", drive_o, 1);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int lf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        reset_checks();
        step(0, 1);
        rst_n = 1'b1;
        // R3 reference pass-through and R1 at divide by 6
        repeat (40) step(0, 1);
        repeat (40) step(1, 1);
        // R4 enable mode
        repeat (10) step(2, 0);
        repeat (10) step(2, 1);
        for (int i = 0; i < 30; i++) step(2, (i % 4 == 1) ? 0 : 1);
        // R5 R7 switch to bank 0 and back
        repeat (30) step(3, 0);
        repeat (30) step(3, 1);
        // R6 single-cycle select pulses at all counter phases
        for (int i = 0; i < 70; i++) step(3, (i % 7 == 3) ? 0 : 1);
        for (int i = 0; i < 40; i++) step(3, (i % 5 == 4) ? 1 : 0);
        // random modes and pin levels
        lf = 32'h1ace;
        for (int i = 0; i < 400; i++) begin
            lf = (lf * 1103515245 + 12345) & 32'h7fffffff;
            step((i < 200) ? 3 : ((lf >> 8) & 3), (lf >> 4) & 1);
        end
        // R9 reset while bank 0 active
        repeat (12) step(3, 0);
        @(posedge clk);
        #2;
        rst_n = 1'b0;
        @(negedge clk);
        reset_checks();
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        repeat (40) step(0, 1);
        @(negedge clk);
        finish_run();
    end

endmodule